// File: doc/BRIEF.md
# Procedure Frame Control Unit

This unit owns the three pointers that shape activation records in a word-addressed store of a stack-oriented processor: the stack top (`sp`), the base of the youngest frame (`mp`) and the boundary of the heap area (`np`). The stack climbs from low addresses. The heap descends from the highest address. Every frame opens with four header words: result, static link, dynamic link and return address, at base+0 through base+3. Frames are built in three steps: mark, call and enter. They are torn down by a single return step. Heap words are handed out and given back by moving `np`.

Commands arrive on a valid/ready channel that carries a 6-bit opcode, a 4-bit `p` field, a 20-bit `q` field and the return PC. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from that edge until the cycle after `done`, so the sender must hold or re-present the next command until then. The store is reached through a single-port memory interface. A read issued in cycle t returns `mem_rdata` in cycle t+1, and a write completes at the edge that ends its cycle. Each command ends with a one-cycle `done`. That cycle also carries `overflow`, the branch target for the PC, and the address of a heap allocation.

Top module: `frame_ctl`

## Requirements
- R1: After reset `sp` is 3, `mp` is 0, `np` is all ones, `cmd_ready` is 1, and `done`, `overflow` and `branch_valid` are 0.
- R2: An accepted command raises `done` for exactly one cycle. `cmd_ready` is 0 from the cycle after acceptance through the `done` cycle. Inputs presented while `cmd_ready` is 0 are not taken. `overflow` and `branch_valid` are 0 outside `done` cycles.
- R3: A growth of n words (n is 4 for mark, q for enter and allocate) succeeds only when n ≤ `np` − `sp`. A release succeeds only when its target is ≥ `sp`. A failing command raises `overflow` with `done`, and it changes no pointer and no memory word.
- R4: Mark (opcode 11) starts a link at `mp` and replaces it p times with the low address bits of the word at link+1. It then writes the link to `sp`+2 and the old `mp` to `sp`+3, and adds 4 to `sp`. Words `sp`+1 and `sp`+4 are not written.
- R5: Call (opcode 12) sets `mp` to `sp`−p−3, writes the zero-extended PC into word `mp`+3, and signals a branch to q.
- R6: Enter (opcode 13) writes the UNDEF pattern into words `sp`+1 through `sp`+q and adds q to `sp`. When q is 0 it writes nothing.
- R7: Return (opcode 14) signals a branch to the word at `mp`+3 and loads `mp` from the word at `mp`+2. It sets `sp` to the old `mp` when p is 1 (function) and to the old `mp`−1 otherwise (procedure).
- R8: Allocate (opcode 62) returns the old `np` on `alloc_addr` and subtracts q from `np`.
- R9: Release (opcode 63) loads `np` with the low address bits of q.
- R10: Any other opcode completes with `done`, without overflow or branch, and it changes no pointer and no memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_op | input | 6 | Opcode |
| cmd_p | input | 4 | P field |
| cmd_q | input | 20 | Q field |
| cmd_pc | input | PC_W | Return PC for a call |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| sp | output | ADDR_W | Stack top |
| mp | output | ADDR_W | Youngest frame base |
| np | output | ADDR_W | Heap boundary |
| done | output | 1 | Command completes this cycle |
| overflow | output | 1 | Command refused for lack of room |
| branch_valid | output | 1 | PC must load `branch_target` |
| branch_target | output | PC_W | New PC |
| alloc_addr | output | ADDR_W | Address returned by the last allocate |

## Verification
A wrong link count or a wrong base offset in mark or call does not show at the pointers at once. It first appears in memory words, and at the ports only when a later return follows the corrupted links. For that reason the whole store is compared against a behavioural model at every `done`, which catches a stray write on the command that made it. A faulty room check shows up as `overflow` in the wrong `done` cycle, or as `sp` crossing `np`. Handshake errors show as `cmd_ready` or the flags misbehaving in the cycle right after acceptance.

// File: rtl/frame_ctl_pkg.sv
package frame_ctl_pkg;
  localparam logic [5:0] OP_MARK    = 6'd11;
  localparam logic [5:0] OP_CALL    = 6'd12;
  localparam logic [5:0] OP_ENTER   = 6'd13;
  localparam logic [5:0] OP_RETURN  = 6'd14;
  localparam logic [5:0] OP_ALLOC   = 6'd62;
  localparam logic [5:0] OP_RELEASE = 6'd63;
  localparam int unsigned HDR_WORDS = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LINK_RQ, ST_LINK_RS, ST_MARK_SL, ST_MARK_DL, ST_CALL,
    ST_FILL, ST_RA_RQ, ST_RA_RS, ST_DL_RQ, ST_DL_RS, ST_DONE
  } fc_state_t;
endpackage

// File: rtl/frame_room.sv
module frame_room #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned NEED_W = 20
) (
  input  logic [ADDR_W-1:0] lo_ptr,
  input  logic [ADDR_W-1:0] hi_ptr,
  input  logic [NEED_W-1:0] need,
  output logic              fits
);
  localparam int unsigned CMP_W = (ADDR_W > NEED_W ? ADDR_W : NEED_W) + 1;
  logic [ADDR_W-1:0] gap;
  always_comb begin
    gap  = hi_ptr - lo_ptr;
    fits = CMP_W'(need) <= CMP_W'(gap);
  end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import frame_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PC_W   = 20,
  parameter logic [31:0] UNDEF  = 32'hA5A5_5A5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [5:0]        cmd_op,
  input  logic [3:0]        cmd_p,
  input  logic [19:0]       cmd_q,
  input  logic [PC_W-1:0]   cmd_pc,
  input  logic              room_ok,
  output logic [19:0]       room_need,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] mp,
  output logic [ADDR_W-1:0] np,
  output logic              done,
  output logic              overflow,
  output logic              branch_valid,
  output logic [PC_W-1:0]   branch_target,
  output logic [ADDR_W-1:0] alloc_addr
);
  localparam logic [ADDR_W-1:0] SP_RST = ADDR_W'(HDR_WORDS - 1);

  fc_state_t         state;
  logic [ADDR_W-1:0] link, base;
  logic [19:0]       cnt, q_r;
  logic [3:0]        p_r;
  logic [PC_W-1:0]   pc_r;
  logic              accept;

  assign accept    = cmd_valid && cmd_ready;
  assign cmd_ready = (state == ST_IDLE);
  assign done      = (state == ST_DONE);
  assign room_need = (cmd_op == OP_MARK) ? 20'(HDR_WORDS) : cmd_q;

  always_comb begin
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
    unique case (state)
      ST_LINK_RQ: begin mem_req = 1'b1; mem_addr = link + ADDR_W'(1); end
      ST_MARK_SL: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp + ADDR_W'(2); mem_wdata = 32'(link); end
      ST_MARK_DL: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp + ADDR_W'(3); mem_wdata = 32'(mp); end
      ST_CALL:    begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = base + ADDR_W'(3); mem_wdata = 32'(pc_r); end
      ST_FILL:    begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp + ADDR_W'(1); mem_wdata = UNDEF; end
      ST_RA_RQ:   begin mem_req = 1'b1; mem_addr = mp + ADDR_W'(3); end
      ST_DL_RQ:   begin mem_req = 1'b1; mem_addr = mp + ADDR_W'(2); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; sp <= SP_RST; mp <= '0; np <= '1;
      link <= '0; base <= '0; cnt <= '0; q_r <= '0; p_r <= '0; pc_r <= '0;
      overflow <= 1'b0; branch_valid <= 1'b0; branch_target <= '0; alloc_addr <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          q_r <= cmd_q; p_r <= cmd_p; pc_r <= cmd_pc;
          state <= ST_DONE;
          unique case (cmd_op)
            OP_MARK: if (!room_ok) overflow <= 1'b1;
                     else begin
                       link <= mp; cnt <= 20'(cmd_p);
                       state <= (cmd_p == 4'd0) ? ST_MARK_SL : ST_LINK_RQ;
                     end
            OP_CALL: begin
              base  <= sp - ADDR_W'(cmd_p) - ADDR_W'(3);
              state <= ST_CALL;
            end
            OP_ENTER: if (!room_ok) overflow <= 1'b1;
                      else if (cmd_q != 20'd0) begin cnt <= cmd_q; state <= ST_FILL; end
            OP_RETURN: state <= ST_RA_RQ;
            OP_ALLOC: if (!room_ok) overflow <= 1'b1;
                      else begin alloc_addr <= np; np <= np - ADDR_W'(cmd_q); end
            OP_RELEASE: if (cmd_q[ADDR_W-1:0] < sp) overflow <= 1'b1;
                        else np <= cmd_q[ADDR_W-1:0];
            default: ;
          endcase
        end
        ST_LINK_RQ: state <= ST_LINK_RS;
        ST_LINK_RS: begin
          link  <= mem_rdata[ADDR_W-1:0];
          cnt   <= cnt - 20'd1;
          state <= (cnt == 20'd1) ? ST_MARK_SL : ST_LINK_RQ;
        end
        ST_MARK_SL: state <= ST_MARK_DL;
        ST_MARK_DL: begin sp <= sp + ADDR_W'(HDR_WORDS); state <= ST_DONE; end
        ST_CALL: begin
          mp <= base; branch_valid <= 1'b1; branch_target <= PC_W'(q_r); state <= ST_DONE;
        end
        ST_FILL: begin
          sp  <= sp + ADDR_W'(1);
          cnt <= cnt - 20'd1;
          if (cnt == 20'd1) state <= ST_DONE;
        end
        ST_RA_RQ: state <= ST_RA_RS;
        ST_RA_RS: begin branch_target <= mem_rdata[PC_W-1:0]; state <= ST_DL_RQ; end
        ST_DL_RQ: state <= ST_DL_RS;
        ST_DL_RS: begin
          mp <= mem_rdata[ADDR_W-1:0];
          sp <= (p_r == 4'd1) ? mp : mp - ADDR_W'(1);
          branch_valid <= 1'b1;
          state <= ST_DONE;
        end
        ST_DONE: begin overflow <= 1'b0; branch_valid <= 1'b0; state <= ST_IDLE; end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_no_cross_R3: assert property (@(posedge clk) disable iff (!rst_n) sp <= np);
  assert_refused_keeps_ptrs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> ($stable(sp) && $stable(mp) && $stable(np)));
  assert_done_reopens_R2: assert property (@(posedge clk) disable iff (!rst_n) done |=> cmd_ready);
  assert_flags_only_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow || branch_valid) |-> done);
  assert_no_mem_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !cmd_ready);
  assert_call_branches_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CALL) |=> (branch_valid && done));
  assert_alloc_returns_np_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == OP_ALLOC && room_ok) |=> (alloc_addr == $past(np)));
endmodule

// File: rtl/frame_ctl.sv
module frame_ctl #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PC_W   = 20,
  parameter logic [31:0] UNDEF  = 32'hA5A5_5A5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [5:0]        cmd_op,
  input  logic [3:0]        cmd_p,
  input  logic [19:0]       cmd_q,
  input  logic [PC_W-1:0]   cmd_pc,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] mp,
  output logic [ADDR_W-1:0] np,
  output logic              done,
  output logic              overflow,
  output logic              branch_valid,
  output logic [PC_W-1:0]   branch_target,
  output logic [ADDR_W-1:0] alloc_addr
);
  logic        room_ok;
  logic [19:0] room_need;

  frame_room #(.ADDR_W(ADDR_W), .NEED_W(20)) u_room (
    .lo_ptr(sp), .hi_ptr(np), .need(room_need), .fits(room_ok)
  );

  frame_seq #(.ADDR_W(ADDR_W), .PC_W(PC_W), .UNDEF(UNDEF)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_p(cmd_p), .cmd_q(cmd_q), .cmd_pc(cmd_pc),
    .room_ok(room_ok), .room_need(room_need),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .sp(sp), .mp(mp), .np(np), .done(done), .overflow(overflow),
    .branch_valid(branch_valid), .branch_target(branch_target),
    .alloc_addr(alloc_addr)
  );
endmodule

// File: tb/tb_frame_ctl.sv
module tb_frame_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int PW = 20;
  localparam int WORDS = 256;
  localparam logic [31:0] UNDEF = 32'hA5A5_5A5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [5:0] cmd_op = '0;
  logic [3:0] cmd_p = '0;
  logic [19:0] cmd_q = '0;
  logic [PW-1:0] cmd_pc = '0;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [AW-1:0] sp, mp, np, alloc_addr;
  logic done, overflow, branch_valid;
  logic [PW-1:0] branch_target;

  int checks = 0, errors = 0;
  bit finished = 0;

  frame_ctl #(.ADDR_W(AW), .PC_W(PW), .UNDEF(UNDEF)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_p(cmd_p), .cmd_q(cmd_q), .cmd_pc(cmd_pc),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .sp(sp), .mp(mp), .np(np), .done(done), .overflow(overflow),
    .branch_valid(branch_valid), .branch_target(branch_target),
    .alloc_addr(alloc_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] ram [WORDS];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) ram[i] <= '0;
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else mem_rdata <= ram[mem_addr];
    end
  end

  // behavioural model
  int m_sp, m_mp, m_np, m_alloc;
  logic [31:0] m_mem [WORDS];
  bit e_ovf, e_br;
  int e_tgt;

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void model(int op, int p, int q, int pc);
    int link;
    e_ovf = 0; e_br = 0;
    case (op)
      11: if (m_np - m_sp < 4) e_ovf = 1;
          else begin
            link = m_mp;
            for (int k = 0; k < p; k++) link = int'(m_mem[(link + 1) % WORDS]) % WORDS;
            m_mem[(m_sp + 2) % WORDS] = 32'(link);
            m_mem[(m_sp + 3) % WORDS] = 32'(m_mp);
            m_sp = m_sp + 4;
          end
      12: begin
            m_mp = (m_sp - p - 3 + WORDS) % WORDS;
            m_mem[(m_mp + 3) % WORDS] = 32'(pc);
            e_br = 1; e_tgt = q;
          end
      13: if (q > m_np - m_sp) e_ovf = 1;
          else begin
            for (int k = 1; k <= q; k++) m_mem[(m_sp + k) % WORDS] = UNDEF;
            m_sp = m_sp + q;
          end
      14: begin
            e_br = 1; e_tgt = int'(m_mem[(m_mp + 3) % WORDS] & 32'hFFFFF);
            link = int'(m_mem[(m_mp + 2) % WORDS]) % WORDS;
            m_sp = (p == 1) ? m_mp : (m_mp - 1 + WORDS) % WORDS;
            m_mp = link;
          end
      62: if (q > m_np - m_sp) e_ovf = 1;
          else begin m_alloc = m_np; m_np = m_np - q; end
      63: if ((q % WORDS) < m_sp) e_ovf = 1; else m_np = q % WORDS;
      default: ;
    endcase
  endfunction

  task automatic run(string req, int op, int p, int q, int pc);
    int wait_cyc;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 6'(op); cmd_p = 4'(p); cmd_q = 20'(q); cmd_pc = PW'(pc);
    while (!cmd_ready) @(negedge clk);
    model(op, p, q, pc);
    @(negedge clk);
    // keep a different command on the channel while busy: it must not be taken
    cmd_op = 6'd62; cmd_q = 20'd1;
    if (!done) check("R2", "ready low while busy", cmd_ready, 0);
    wait_cyc = 0;
    while (!done && wait_cyc < 100) begin @(negedge clk); wait_cyc++; end
    cmd_valid = 1'b0;
    check("R2", "done reached", done, 1);
    check(req, "sp", sp, m_sp);
    check(req, "mp", mp, m_mp);
    check(req, "np", np, m_np);
    check(req, "overflow", overflow, e_ovf);
    check(req, "branch_valid", branch_valid, e_br);
    if (e_br) check(req, "branch_target", branch_target, e_tgt);
    if (op == 62 && !e_ovf) check(req, "alloc_addr", alloc_addr, m_alloc);
    begin
      int bad = 0;
      for (int i = 0; i < WORDS; i++) if (ram[i] !== m_mem[i]) bad++;
      check(req, "memory words differing", bad, 0);
    end
    @(negedge clk);
    check("R2", "single done pulse", done, 0);
  endtask

  // per-cycle port rules
  always @(negedge clk) if (rst_n && !finished) begin
    if (!done && (overflow || branch_valid)) check("R2", "flag outside done", 1, 0);
    if (sp > np) check("R3", "sp crossed np", sp, np);
  end

  initial begin
    repeat (400000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_sp = 3; m_mp = 0; m_np = WORDS - 1; m_alloc = 0;
    for (int i = 0; i < WORDS; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "sp", sp, 3); check("R1", "mp", mp, 0); check("R1", "np", np, WORDS - 1);
    check("R1", "ready", cmd_ready, 1); check("R1", "done", done, 0);
    check("R1", "overflow", overflow, 0); check("R1", "branch", branch_valid, 0);

    run("R4", 11, 0, 0, 0);
    run("R6", 13, 0, 1, 0);
    run("R5", 12, 1, 100, 7);
    run("R6", 13, 0, 3, 0);
    run("R4", 11, 1, 0, 0);
    run("R5", 12, 0, 200, 33);
    run("R4", 11, 2, 0, 0);
    run("R5", 12, 0, 300, 55);
    run("R7", 14, 1, 0, 0);
    run("R7", 14, 0, 0, 0);
    run("R6", 13, 0, 0, 0);
    run("R8", 62, 0, 10, 0);
    run("R3", 62, 0, 300, 0);
    run("R3", 13, 0, 250, 0);
    run("R3", 63, 0, 5, 0);
    run("R9", 63, 0, 255, 0);
    run("R10", 7, 3, 9, 0);
    run("R8", 62, 0, 240, 0);
    run("R3", 11, 0, 0, 0);
    run("R3", 11, 0, 0, 0);
    run("R8", 62, 0, 0, 0);
    run("R7", 14, 0, 0, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule